// File: doc/BRIEF.md
# Cellular modem power sequencer

This block sits in a host controller and owns the two active-low control lines of an external cellular modem: the power key and the hard-shutdown line. On request it runs a timed power-on procedure or a timed power-off procedure. Either procedure can escalate to a forced shutdown, and a forced shutdown can end in removal of the modem supply. The block reads a power-monitor input from the modem and a battery-good flag from an external comparator. An AT-command handshake is reduced to two pulses: the block emits a probe strobe, and the host's command parser returns an answer strobe.

Both control lines are open-drain. The block only ever outputs a pull-low enable for each line and never drives a line high. A host-I/O gate output tells the host when the modem's digital pins may see high levels. Four status outputs report on, off, busy and a sticky error. The error is set whenever a forced shutdown begins.

All delays are counted in milliseconds. A prescaler of `CLK_PER_MS` clock cycles generates the millisecond tick, and each step of a procedure restarts the count from zero when the step begins. A step of N ms therefore lasts exactly N*CLK_PER_MS+1 clock cycles. The power-monitor and answer inputs are asynchronous and pass through a two-flop synchronizer.

Top module: `modem_pwr_seq`

## Requirements
- R1: After a synchronous active-low reset, the block is idle:
  - `pwrkey_pull`, `shdn_pull`, `supply_cut`, `at_probe` and `st_err` are 0.
  - `st_off` is 1 while the synchronized monitor reads off.
- R2: An on request while idle with `batt_ok` low starts no sequence. `st_busy` stays 0 and `pwrkey_pull` stays 0.
- R3: An on request while idle with `batt_ok` high and the monitor already on skips the key press and goes straight to the AT check.
- R4: An on request while idle with `batt_ok` high and the monitor off holds `pwrkey_pull` for T_ON_KEY_MS. At release, the next step depends on the monitor:
  - monitor on: a wait of T_ON_SETTLE_MS, then the AT check;
  - monitor off: forced shutdown.
- R5: The AT check runs in this order:
  - it waits T_AT_WAIT_MS;
  - it pulses `at_probe` for exactly one cycle;
  - it waits up to T_AT_ANS_MS for the synchronized answer. An answer returns the block to idle with the modem on. No answer starts forced shutdown.
- R6: An off request while idle with the monitor on holds `pwrkey_pull` for T_OFF_KEY_MS. After release, the block polls the monitor and returns to idle as soon as the monitor reads off.
- R7: If the monitor still reads on T_OFF_LIMIT_MS after the power-off key release, the block starts forced shutdown.
- R8: Forced shutdown runs in this order:
  - it holds `shdn_pull` for T_SD_PULL_MS;
  - it waits T_SD_WAIT_MS;
  - if the monitor still reads on, it raises `supply_cut`; otherwise it returns to idle.
  - `supply_cut` stays high until an on request, which lowers it and returns the block to idle.
- R9: At most one of `pwrkey_pull`, `shdn_pull`, `supply_cut` and `at_probe` is 1 in any cycle.
- R10: `io_gate` is 1 only when the block is idle and the monitor reads on. It is 0 during every transition and while the modem is off.
- R11: `st_err` is set when forced shutdown begins. It is cleared by the next on request that is accepted in idle or in the supply-cut state.
- R12: Requests are ignored in these cases:
  - On and off requests that arrive while a sequence runs (`st_busy` = 1) have no effect.
  - Off requests in the supply-cut state have no effect.
- R13: The monitor input reaches the status outputs two clock cycles after it changes (two-flop synchronizer).
- R14: Each timed step of N ms lasts N*CLK_PER_MS+1 clock cycles, counted from the step's first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| on_req | input | 1 | Power-on request pulse |
| off_req | input | 1 | Power-off request pulse |
| batt_ok | input | 1 | Battery-above-threshold flag from an external comparator |
| pwrmon_in | input | 1 | Asynchronous power-monitor level from the modem |
| at_ans_in | input | 1 | Asynchronous answer strobe from the AT parser |
| at_probe | output | 1 | One-cycle request to send the AT probe |
| pwrkey_pull | output | 1 | Pull-low enable for the power-key line |
| shdn_pull | output | 1 | Pull-low enable for the hard-shutdown line |
| supply_cut | output | 1 | Request to remove the modem supply |
| io_gate | output | 1 | Host digital I/O toward the modem may be driven |
| st_on | output | 1 | Idle with the modem on |
| st_off | output | 1 | Idle with the modem off, or supply cut |
| st_busy | output | 1 | A sequence is running |
| st_err | output | 1 | Sticky forced-shutdown error |

## Verification
The embedded assertions check the following on every cycle:
- the output exclusivity of R9;
- the I/O gate staying closed whenever a line is pulled or a sequence runs;
- the single-cycle probe;
- the battery gate on a power-on press;
- the minimum key-press lengths, taken from the step timer;
- the error flag being up throughout any shutdown pulse;
- supply cut being entered only from the post-shutdown wait with the monitor still on.

The following can only be shown by the bench's scenarios, against its cycle-accurate behavioural model:
- the exact step lengths;
- the branch taken at each monitor decision point;
- the 15-second-style escalation;
- requests ignored while a sequence runs;
- clearing of the error and of the supply cut by a later on request.

// File: rtl/pwrseq_pkg.sv
// Package: shared state encoding for the modem power sequencer.
// Assumes nothing beyond a single clock domain for the consumers.
package pwrseq_pkg;

    typedef enum logic [3:0] {
        PS_IDLE      = 4'd0,
        PS_ON_KEY    = 4'd1,
        PS_ON_SETTLE = 4'd2,
        PS_AT_WAIT   = 4'd3,
        PS_AT_PROBE  = 4'd4,
        PS_AT_ANS    = 4'd5,
        PS_OFF_KEY   = 4'd6,
        PS_OFF_POLL  = 4'd7,
        PS_SD_PULL   = 4'd8,
        PS_SD_WAIT   = 4'd9,
        PS_CUT       = 4'd10
    } pstate_t;

endpackage

// File: rtl/pwrseq_sync.sv
// Module: two-flop synchronizer for a vector of independent asynchronous bits.
// Assumes each bit is a slow level or a pulse of several clock cycles;
// no bus coherency is implied between bits.
module pwrseq_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    // Two register stages, cleared by the synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/pwrseq_timer.sv
// Module: step timer. A prescaler of CLK_PER_MS cycles feeds a saturating
// millisecond counter. Both restart from zero on clr, so ms_o reads the whole
// milliseconds elapsed since the cycle in which clr was last high.
// Assumes MS_W is wide enough for the longest step plus one.
module pwrseq_timer #(
    parameter int CLK_PER_MS = 100000,
    parameter int MS_W       = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic [MS_W-1:0] ms_o
);

    localparam int PW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_MS - 1);

    logic [PW-1:0] pre;
    logic          tick;

    assign tick = (pre == PRE_LAST);

    // Prescaler: wraps every CLK_PER_MS cycles, restarts on clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pre <= '0;
        else if (tick)     pre <= '0;
        else               pre <= pre + 1'b1;
    end

    // Millisecond counter: saturates at all ones, restarts on clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)         ms_o <= '0;
        else if (tick && ~&ms_o)   ms_o <= ms_o + 1'b1;
    end

    // R14: the millisecond count moves by at most one and only on a tick
    AST_MS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) && $past(rst_n) |-> (ms_o == $past(ms_o)) || (ms_o == $past(ms_o) + 1'b1)); // R14

endmodule

// File: rtl/modem_pwr_seq.sv
// Module: host-side power sequencer for an external cellular modem.
// Runs power-on (with AT check), power-off (with escalation) and forced
// shutdown (with supply removal) as a single state machine whose steps are
// timed by pwrseq_timer. Assumes pwrmon_in and at_ans_in are asynchronous,
// batt_ok and the request pulses are synchronous to clk, and all *_MS
// parameters are at least 1.
module modem_pwr_seq
    import pwrseq_pkg::*;
#(
    parameter int CLK_PER_MS      = 100000,
    parameter int T_ON_KEY_MS     = 5000,
    parameter int T_ON_SETTLE_MS  = 1000,
    parameter int T_AT_WAIT_MS    = 300,
    parameter int T_AT_ANS_MS     = 1000,
    parameter int T_OFF_KEY_MS    = 3000,
    parameter int T_OFF_LIMIT_MS  = 15000,
    parameter int T_SD_PULL_MS    = 200,
    parameter int T_SD_WAIT_MS    = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on_req,
    input  logic off_req,
    input  logic batt_ok,
    input  logic pwrmon_in,
    input  logic at_ans_in,
    output logic at_probe,
    output logic pwrkey_pull,
    output logic shdn_pull,
    output logic supply_cut,
    output logic io_gate,
    output logic st_on,
    output logic st_off,
    output logic st_busy,
    output logic st_err
);

    localparam int MAX_A  = (T_ON_KEY_MS > T_ON_SETTLE_MS) ? T_ON_KEY_MS : T_ON_SETTLE_MS;
    localparam int MAX_B  = (T_AT_WAIT_MS > T_AT_ANS_MS) ? T_AT_WAIT_MS : T_AT_ANS_MS;
    localparam int MAX_C  = (T_OFF_KEY_MS > T_OFF_LIMIT_MS) ? T_OFF_KEY_MS : T_OFF_LIMIT_MS;
    localparam int MAX_D  = (T_SD_PULL_MS > T_SD_WAIT_MS) ? T_SD_PULL_MS : T_SD_WAIT_MS;
    localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CD = (MAX_C > MAX_D) ? MAX_C : MAX_D;
    localparam int MAX_MS = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int MS_W   = $clog2(MAX_MS + 2);

    localparam logic [MS_W-1:0] LIM_ON_KEY  = MS_W'(T_ON_KEY_MS);
    localparam logic [MS_W-1:0] LIM_SETTLE  = MS_W'(T_ON_SETTLE_MS);
    localparam logic [MS_W-1:0] LIM_AT_WAIT = MS_W'(T_AT_WAIT_MS);
    localparam logic [MS_W-1:0] LIM_AT_ANS  = MS_W'(T_AT_ANS_MS);
    localparam logic [MS_W-1:0] LIM_OFF_KEY = MS_W'(T_OFF_KEY_MS);
    localparam logic [MS_W-1:0] LIM_OFF_MAX = MS_W'(T_OFF_LIMIT_MS);
    localparam logic [MS_W-1:0] LIM_SD_PULL = MS_W'(T_SD_PULL_MS);
    localparam logic [MS_W-1:0] LIM_SD_WAIT = MS_W'(T_SD_WAIT_MS);

    pstate_t         state, nxt;
    logic [1:0]      sync_q;
    logic            mon_s, ans_s;
    logic [MS_W-1:0] ms_cnt;
    logic            step_clr;
    logic            err_q, err_clr;

    pwrseq_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({at_ans_in, pwrmon_in}),
        .q     (sync_q)
    );
    assign mon_s = sync_q[0];
    assign ans_s = sync_q[1];

    assign step_clr = (nxt != state);

    pwrseq_timer #(.CLK_PER_MS(CLK_PER_MS), .MS_W(MS_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (step_clr),
        .ms_o  (ms_cnt)
    );

    // Next-state selection for every step of the three procedures.
    always_comb begin
        nxt     = state;
        err_clr = 1'b0;
        unique case (state)
            PS_IDLE: begin
                if (on_req) begin
                    err_clr = 1'b1;
                    if (batt_ok) nxt = mon_s ? PS_AT_WAIT : PS_ON_KEY;
                end else if (off_req && mon_s) begin
                    nxt = PS_OFF_KEY;
                end
            end
            PS_ON_KEY:    if (ms_cnt >= LIM_ON_KEY)  nxt = mon_s ? PS_ON_SETTLE : PS_SD_PULL;
            PS_ON_SETTLE: if (ms_cnt >= LIM_SETTLE)  nxt = PS_AT_WAIT;
            PS_AT_WAIT:   if (ms_cnt >= LIM_AT_WAIT) nxt = PS_AT_PROBE;
            PS_AT_PROBE:  nxt = PS_AT_ANS;
            PS_AT_ANS: begin
                if (ans_s)                          nxt = PS_IDLE;
                else if (ms_cnt >= LIM_AT_ANS)      nxt = PS_SD_PULL;
            end
            PS_OFF_KEY:   if (ms_cnt >= LIM_OFF_KEY) nxt = PS_OFF_POLL;
            PS_OFF_POLL: begin
                if (!mon_s)                         nxt = PS_IDLE;
                else if (ms_cnt >= LIM_OFF_MAX)     nxt = PS_SD_PULL;
            end
            PS_SD_PULL:   if (ms_cnt >= LIM_SD_PULL) nxt = PS_SD_WAIT;
            PS_SD_WAIT:   if (ms_cnt >= LIM_SD_WAIT) nxt = mon_s ? PS_CUT : PS_IDLE;
            PS_CUT: begin
                if (on_req) begin
                    nxt     = PS_IDLE;
                    err_clr = 1'b1;
                end
            end
            default: nxt = PS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_IDLE;
        else        state <= nxt;
    end

    // Sticky error: set on entry to forced shutdown, cleared by an accepted on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         err_q <= 1'b0;
        else if (nxt == PS_SD_PULL && state != PS_SD_PULL)  err_q <= 1'b1;
        else if (err_clr)                                   err_q <= 1'b0;
    end

    assign pwrkey_pull = (state == PS_ON_KEY) || (state == PS_OFF_KEY);
    assign shdn_pull   = (state == PS_SD_PULL);
    assign supply_cut  = (state == PS_CUT);
    assign at_probe    = (state == PS_AT_PROBE);
    assign st_on       = (state == PS_IDLE) && mon_s;
    assign st_off      = ((state == PS_IDLE) && !mon_s) || (state == PS_CUT);
    assign st_busy     = (state != PS_IDLE) && (state != PS_CUT);
    assign io_gate     = (state == PS_IDLE) && mon_s;
    assign st_err      = err_q;

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pwrkey_pull, shdn_pull, supply_cut, at_probe})); // R9
    AST_GATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        io_gate |-> !pwrkey_pull && !shdn_pull && !st_busy && !supply_cut); // R10
    AST_PROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        at_probe |=> !at_probe); // R5
    AST_BATT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwrkey_pull) && state == PS_ON_KEY |-> $past(batt_ok)); // R2
    AST_ON_KEY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwrkey_pull) && $past(state == PS_ON_KEY) |-> $past(ms_cnt) >= LIM_ON_KEY); // R4
    AST_OFF_KEY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwrkey_pull) && $past(state == PS_OFF_KEY) |-> $past(ms_cnt) >= LIM_OFF_KEY); // R6
    AST_ERR_IN_SD: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_pull |-> st_err); // R11
    AST_CUT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_cut) |-> $past(state == PS_SD_WAIT) && $past(mon_s)); // R8

endmodule

// File: tb/tb_modem_pwr_seq.sv
module tb_modem_pwr_seq;

    localparam int P      = 4;
    localparam int ONK    = 10;
    localparam int SETL   = 4;
    localparam int ATW    = 3;
    localparam int ATA    = 6;
    localparam int OFFK   = 6;
    localparam int OFFL   = 20;
    localparam int SDP    = 2;
    localparam int SDW    = 5;

    localparam int M_IDLE = 0, M_ONK = 1, M_SETL = 2, M_ATW = 3, M_PRB = 4, M_ATA = 5,
                   M_OFFK = 6, M_POLL = 7, M_SDP = 8, M_SDW = 9, M_CUT = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic on_req = 1'b0, off_req = 1'b0, batt_ok = 1'b0, mon_raw = 1'b0, ans_raw = 1'b0;
    logic at_probe, pwrkey_pull, shdn_pull, supply_cut, io_gate, st_on, st_off, st_busy, st_err;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    modem_pwr_seq #(
        .CLK_PER_MS(P), .T_ON_KEY_MS(ONK), .T_ON_SETTLE_MS(SETL), .T_AT_WAIT_MS(ATW),
        .T_AT_ANS_MS(ATA), .T_OFF_KEY_MS(OFFK), .T_OFF_LIMIT_MS(OFFL),
        .T_SD_PULL_MS(SDP), .T_SD_WAIT_MS(SDW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req), .batt_ok(batt_ok),
        .pwrmon_in(mon_raw), .at_ans_in(ans_raw), .at_probe(at_probe),
        .pwrkey_pull(pwrkey_pull), .shdn_pull(shdn_pull), .supply_cut(supply_cut),
        .io_gate(io_gate), .st_on(st_on), .st_off(st_off), .st_busy(st_busy), .st_err(st_err)
    );

    // Behavioural reference: step number, cycles in step, error flag, input delay lines.
    int m_st = M_IDLE, m_nx = M_IDLE, m_cnt = 0;
    bit m_err = 0, m_clr = 0, m_mq1 = 0, m_mq2 = 0, m_aq1 = 0, m_aq2 = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = M_IDLE; m_cnt = 0; m_err = 0;
            m_mq1 = 0; m_mq2 = 0; m_aq1 = 0; m_aq2 = 0;
        end else begin
            m_nx = m_st; m_clr = 0;
            case (m_st)
                M_IDLE: if (on_req) begin
                            m_clr = 1;
                            if (batt_ok) m_nx = m_mq2 ? M_ATW : M_ONK;
                        end else if (off_req && m_mq2) m_nx = M_OFFK;
                M_ONK:  if (m_cnt >= ONK * P) m_nx = m_mq2 ? M_SETL : M_SDP;
                M_SETL: if (m_cnt >= SETL * P) m_nx = M_ATW;
                M_ATW:  if (m_cnt >= ATW * P) m_nx = M_PRB;
                M_PRB:  m_nx = M_ATA;
                M_ATA:  if (m_aq2) m_nx = M_IDLE; else if (m_cnt >= ATA * P) m_nx = M_SDP;
                M_OFFK: if (m_cnt >= OFFK * P) m_nx = M_POLL;
                M_POLL: if (!m_mq2) m_nx = M_IDLE; else if (m_cnt >= OFFL * P) m_nx = M_SDP;
                M_SDP:  if (m_cnt >= SDP * P) m_nx = M_SDW;
                M_SDW:  if (m_cnt >= SDW * P) m_nx = m_mq2 ? M_CUT : M_IDLE;
                M_CUT:  if (on_req) begin m_nx = M_IDLE; m_clr = 1; end
                default: m_nx = M_IDLE;
            endcase
            if (m_nx == M_SDP && m_st != M_SDP) m_err = 1;
            else if (m_clr) m_err = 0;
            m_cnt = (m_nx != m_st) ? 0 : m_cnt + 1;
            m_st = m_nx;
            m_mq2 = m_mq1; m_mq1 = mon_raw;
            m_aq2 = m_aq1; m_aq1 = ans_raw;
        end
    end

    task automatic cmp(input logic act, input logic exp, input string tag);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    task automatic chk(input int act, input int exp, input string tag);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Per-cycle comparison of every output against the reference.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp(pwrkey_pull, m_st == M_ONK || m_st == M_OFFK, "R4/R6 pwrkey_pull");
            cmp(shdn_pull, m_st == M_SDP, "R8 shdn_pull");
            cmp(supply_cut, m_st == M_CUT, "R8 supply_cut");
            cmp(at_probe, m_st == M_PRB, "R5 at_probe");
            cmp(io_gate, m_st == M_IDLE && m_mq2, "R10 io_gate");
            cmp(st_on, m_st == M_IDLE && m_mq2, "R13 st_on");
            cmp(st_off, (m_st == M_IDLE && !m_mq2) || m_st == M_CUT, "R13 st_off");
            cmp(st_busy, m_st != M_IDLE && m_st != M_CUT, "R12 st_busy");
            cmp(st_err, m_err, "R11 st_err");
        end
    end

    task automatic pulse_on;
        @(negedge clk); on_req = 1'b1;
        @(negedge clk); on_req = 1'b0;
    endtask

    task automatic pulse_off;
        @(negedge clk); off_req = 1'b1;
        @(negedge clk); off_req = 1'b0;
    endtask

    task automatic answer_probe;
        while (!at_probe) @(negedge clk);
        chk(io_gate, 0, "R10 gate closed during AT check");
        repeat (2) @(negedge clk);
        ans_raw = 1'b1;
        @(negedge clk); ans_raw = 1'b0;
    endtask

    task automatic wait_idle;
        while (st_busy) @(negedge clk);
    endtask

    initial begin
        int n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pwrkey_pull + shdn_pull + supply_cut + at_probe + st_err, 0, "R1 lines released");
        chk(st_off, 1, "R1 st_off");

        // R13: monitor reaches status two edges later
        mon_raw = 1'b1;
        @(negedge clk); chk(st_on, 0, "R13 one edge");
        @(negedge clk); chk(st_on, 1, "R13 two edges");
        mon_raw = 1'b0;
        repeat (3) @(negedge clk);

        // R2: battery low refuses power-on
        pulse_on;
        repeat (3) @(negedge clk);
        chk(st_busy + pwrkey_pull, 0, "R2 refused");

        // R4/R14/R12: normal power-on with key press
        batt_ok = 1'b1;
        pulse_on;
        chk(pwrkey_pull, 1, "R4 key pressed");
        n = 0;
        while (pwrkey_pull) begin
            n++;
            if (n == 3) mon_raw = 1'b1;
            if (n == 5) off_req = 1'b1;
            if (n == 6) begin off_req = 1'b0; chk(pwrkey_pull, 1, "R12 off ignored"); end
            @(negedge clk);
        end
        chk(n, ONK * P + 1, "R14 on key length");
        answer_probe;
        wait_idle;
        chk(st_on + io_gate, 2, "R5 on after answer");
        chk(st_err, 0, "R5 no error");

        // R3: already on, skip key; no answer -> forced shutdown
        pulse_on;
        n = 0;
        while (!at_probe) begin n += pwrkey_pull; @(negedge clk); end
        chk(n, 0, "R3 no key press");
        while (!shdn_pull) @(negedge clk);
        chk(st_err, 1, "R5 timeout forces shutdown");
        n = 0;
        while (shdn_pull) begin n++; @(negedge clk); end
        chk(n, SDP * P + 1, "R8 shutdown pulse length");
        mon_raw = 1'b0;
        wait_idle;
        chk(supply_cut, 0, "R8 no cut when off");
        chk(st_err, 1, "R11 error sticky");

        // R11/R4: accepted on request clears error; monitor off after press -> shutdown
        pulse_on;
        @(negedge clk);
        chk(st_err, 0, "R11 cleared by on request");
        while (!shdn_pull) @(negedge clk);
        chk(st_err, 1, "R4 monitor off forces shutdown");
        wait_idle;
        chk(st_off, 1, "R4 ends off");

        // R6: power-off with monitor dropping
        mon_raw = 1'b1;
        repeat (3) @(negedge clk);
        pulse_on;
        answer_probe;
        wait_idle;
        chk(st_on, 1, "R6 precondition on");
        pulse_off;
        n = 0;
        while (pwrkey_pull) begin n++; @(negedge clk); end
        chk(n, OFFK * P + 1, "R6 off key length");
        repeat (5) @(negedge clk);
        mon_raw = 1'b0;
        wait_idle;
        chk(st_off, 1, "R6 off after poll");
        chk(st_err, 0, "R6 no error");

        // R7/R8: monitor stuck on -> escalate, then cut supply
        mon_raw = 1'b1;
        repeat (3) @(negedge clk);
        pulse_on;
        answer_probe;
        wait_idle;
        pulse_off;
        while (!shdn_pull) @(negedge clk);
        chk(st_err, 1, "R7 escalation");
        while (!supply_cut && st_busy) @(negedge clk);
        chk(supply_cut, 1, "R8 supply cut");
        pulse_off;
        @(negedge clk);
        chk(supply_cut, 1, "R12 off ignored in cut");
        pulse_on;
        @(negedge clk);
        chk(supply_cut + st_err, 0, "R8 cut released by on request");
        repeat (4) @(negedge clk);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule